// File: doc/BRIEF.md
# I2C Register Target with Write Lock

This block is an I2C target that gives a controller access to a bank of 32-bit registers. The SCL and SDA lines are sampled by a faster system clock. The block finds start, repeated start and stop conditions and compares the first byte of each transfer against a configured 7-bit device address. A write transfer then carries a register pointer byte. Each register moves as a group of four bytes, most significant byte first. The pointer steps by one after every complete register, so a single transfer can read or write a run of neighbouring registers.

The bank has three kinds of register. General storage words sit at the low addresses. Two read-only words return 12-bit sensor samples (a magnetic field reading and a temperature reading) widened with sign. A sleep control word drives a pin of the block. All writes to storage are refused until a fixed key word is written to the key register. After that the bank stays open until reset. The sleep bit ignores the lock. Reads are allowed at any time. SDA is an open-drain output: the block only raises an enable that pulls the line low.

Top module: `i2c_lockreg_target`

## Requirements
- R1: A start or stop condition seen at any point, including in the middle of a byte, aborts the transfer in progress. After a start, the next byte is taken as an address byte. A stop releases SDA.
- R2: The first byte after a start carries the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). SDA is pulled low in the ninth clock only when bits 7:1 equal `dev_addr_i`. On a mismatch, SDA stays released, including during any later byte, until the next start.
- R3: In a write transfer, the byte after the address byte sets the register pointer. Each following byte is acknowledged. Four data bytes, first byte = bits 31:24, form one word, and the word is committed when the fourth byte is acknowledged. A register left with fewer than four bytes is not changed.
- R4: The pointer steps by one after each complete four-byte register in both writes and reads, so bursts reach consecutive addresses.
- R5: A read is a pointer write, a repeated start, then the address with bit 0 = 1. Bits 31:24 of the pointed register come first. An acknowledge after a register's fourth byte continues with bits 31:24 of the next address. A not-acknowledge ends transmission, and SDA stays released until a start or stop.
- R6: Writes to the storage words (addresses 0x00 to 0x07) are refused while the bank is locked. Writing 0x2C413534 to address 0x24 unlocks the bank until reset. Address 0x24 reads back 1 in bit 0 when unlocked and 0 when locked. No other write changes the lock state.
- R7: Bit 0 of address 0x20 is the sleep bit. It can be written whether the bank is locked or not. It drives `sleep_o` and reads back in bit 0.
- R8: Address 0x1F returns `field_i` and address 0x1D returns `temp_i`, each a 12-bit two's-complement value sign-extended to 32 bits. Writes to these addresses have no effect.
- R9: SCL and SDA pass through a two-flop synchronizer. The SDA enable is asserted only a few system clocks after a detected SCL falling edge, and it holds steady while SCL is high.
- R10: After reset, SDA is released, the bank is locked, `sleep_o` is 0, and storage reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_addr_i | input | 7 | Configured 7-bit device address |
| field_i | input | 12 | Signed field sample, read at 0x1F |
| temp_i | input | 12 | Signed temperature sample, read at 0x1D |
| sleep_o | output | 1 | Sleep control bit (0x20 bit 0) |

## Verification
The bench drives the block with single-register and multi-register transfers in both directions. Comparing them shows whether the pointer advances only on four-byte boundaries and whether the byte order holds across register borders.

Several transfer shapes test the guards:
- Transfers cut short by a stop after three bytes, or by a start in the middle of a byte, show whether a partial word is kept or discarded.
- A foreign address shows whether the block keeps quiet.
- A read ended with a not-acknowledge shows whether the block releases SDA.

Writes to storage, to the sleep word and to the key register are issued both before and after the correct key, and with a wrong key. These separate the lock from the sleep exemption.

Sensor inputs at the negative limit and the positive limit check the sign extension.

// File: rtl/i2c_lockreg_pkg.sv
package i2c_lockreg_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = 7;
  localparam int SENS_W = 12;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_WR, PH_RD, PH_SKIP
  } phase_t;

  // Sign-extend a sensor sample to a full register word.
  function automatic logic [WORD_W-1:0] widen_signed(input logic [SENS_W-1:0] v);
    return {{(WORD_W-SENS_W){v[SENS_W-1]}}, v};
  endfunction

  // Address byte hit: bits 7:1 compared, bit 0 is direction.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] first,
                                    input logic [ADDR_W-1:0] dev);
    return first[BYTE_W-1:1] == dev;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_bit   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_bit;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_bit;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_lockreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int NBYTE  = WORD_W / BYTE_W;
  localparam int BIDX_W = $clog2(NBYTE);
  localparam logic [BIDX_W-1:0] LAST_B = BIDX_W'(NBYTE-1);

  phase_t              phase;
  logic [3:0]          bitcnt;
  logic [BYTE_W-1:0]   shreg, txsh;
  logic                rw, mack, tx_load;
  logic [BIDX_W-1:0]   bidx;
  logic [WORD_W-1:0]   stage, rd_shift, word_now;
  logic [2:0]          bsel;
  logic                active;

  assign active   = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign word_now = (bidx == '0) ? rd_data : rd_shift;
  assign bsel     = 3'd7 - bitcnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
      rw <= 1'b0; mack <= 1'b0; tx_load <= 1'b0; bidx <= '0;
      stage <= '0; rd_shift <= '0; ptr <= '0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en   <= 1'b0;
      tx_load <= 1'b0;
      if (start_det || stop_det) begin
        phase  <= start_det ? PH_ADDR : PH_IDLE;
        bitcnt <= '0;
        bidx   <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (tx_load) begin
          txsh     <= word_now[WORD_W-1 -: BYTE_W];
          rd_shift <= word_now << BYTE_W;
          sda_oe   <= ~word_now[WORD_W-1];
        end
        if (scl_rise && active) begin
          if (bitcnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_bit};
          else               mack  <= ~sda_bit;
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall && active) begin
          if (bitcnt == 4'd8) begin
            unique case (phase)
              PH_ADDR: if (addr_hit(shreg, dev_addr)) begin
                         sda_oe <= 1'b1;
                         rw     <= shreg[0];
                       end else phase <= PH_SKIP;
              PH_PTR:  begin sda_oe <= 1'b1; ptr <= shreg; bidx <= '0; end
              PH_WR:   begin
                         sda_oe <= 1'b1;
                         stage  <= {stage[WORD_W-BYTE_W-1:0], shreg};
                         if (bidx == LAST_B) begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= {stage[WORD_W-BYTE_W-1:0], shreg};
                           ptr     <= ptr + 1'b1;
                           bidx    <= '0;
                         end else bidx <= bidx + 1'b1;
                       end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            unique case (phase)
              PH_ADDR: if (rw) begin phase <= PH_RD; bidx <= '0; tx_load <= 1'b1; end
                       else phase <= PH_PTR;
              PH_PTR:  phase <= PH_WR;
              PH_RD:   if (mack) begin
                         tx_load <= 1'b1;
                         if (bidx == LAST_B) begin bidx <= '0; ptr <= ptr + 1'b1; end
                         else bidx <= bidx + 1'b1;
                       end else phase <= PH_SKIP;
              default: ;
            endcase
          end else if (phase == PH_RD && bitcnt != 4'd0) begin
            sda_oe <= ~txsh[bsel];
          end
        end
      end
    end
  end

  // R9
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_fall) || $past(tx_load)));
  // R2
  skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_oe);
  // R1
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == PH_ADDR && bitcnt == 4'd0 && bidx == '0 && !sda_oe));
  // R3
  commit_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sda_oe && phase == PH_WR));
endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank
  import i2c_lockreg_pkg::*;
#(
  parameter int                NSTORE     = 8,
  parameter logic [PTR_W-1:0]  FIELD_ADDR = 8'h1F,
  parameter logic [PTR_W-1:0]  TEMP_ADDR  = 8'h1D,
  parameter logic [PTR_W-1:0]  SLEEP_ADDR = 8'h20,
  parameter logic [PTR_W-1:0]  KEY_ADDR   = 8'h24,
  parameter logic [WORD_W-1:0] KEY_WORD   = 32'h2C41_3534
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SENS_W-1:0] field_i,
  input  logic [SENS_W-1:0] temp_i,
  output logic [WORD_W-1:0] rd_data,
  output logic              sleep_o
);
  localparam int SIDX_W = $clog2(NSTORE);

  logic [NSTORE-1:0][WORD_W-1:0] store;
  logic unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store    <= '0;
      unlocked <= 1'b0;
      sleep_o  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr < PTR_W'(NSTORE)) begin
        if (unlocked) store[wr_addr[SIDX_W-1:0]] <= wr_data;
      end else if (wr_addr == SLEEP_ADDR) begin
        sleep_o <= wr_data[0];
      end else if (wr_addr == KEY_ADDR && wr_data == KEY_WORD) begin
        unlocked <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (ptr < PTR_W'(NSTORE))  rd_data = store[ptr[SIDX_W-1:0]];
    else if (ptr == FIELD_ADDR) rd_data = widen_signed(field_i);
    else if (ptr == TEMP_ADDR)  rd_data = widen_signed(temp_i);
    else if (ptr == SLEEP_ADDR) rd_data = {{(WORD_W-1){1'b0}}, sleep_o};
    else if (ptr == KEY_ADDR)   rd_data = {{(WORD_W-1){1'b0}}, unlocked};
  end

  // R6
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);
  // R6
  locked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(store));
  // R7
  sleep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SLEEP_ADDR) |=> (sleep_o == $past(wr_data[0])));
endmodule

// File: rtl/i2c_lockreg_target.sv
module i2c_lockreg_target
  import i2c_lockreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [SENS_W-1:0] field_i,
  input  logic [SENS_W-1:0] temp_i,
  output logic              sleep_o
);
  logic sda_bit, scl_rise, scl_fall, start_det, stop_det, wr_en;
  logic [PTR_W-1:0]  ptr, wr_addr;
  logic [WORD_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr_i), .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  lockreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .field_i(field_i), .temp_i(temp_i),
    .rd_data(rd_data), .sleep_o(sleep_o)
  );
endmodule

// File: tb/i2c_lockreg_target_bench.sv
module i2c_lockreg_target_bench;
  localparam logic [6:0] DEV = 7'h6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [11:0] field_v = '0;
  logic [11:0] temp_v = '0;
  logic sda_oe, sleep_o;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_lockreg_target u_i2c_lockreg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .dev_addr_i(DEV), .field_i(field_v),
    .temp_i(temp_v), .sleep_o(sleep_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic w8(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w8(8); scl_m = 1'b1; w8(8); sda_m = 1'b0; w8(8); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w8(5); sda_m = 1'b0; w8(5); scl_m = 1'b1; w8(8); sda_m = 1'b1; w8(10);
  endtask

  task automatic bit_out(input logic b);
    w8(5); sda_m = b; w8(5); scl_m = 1'b1; w8(10); scl_m = 1'b0;
  endtask

  // Sends a byte and reports whether the target pulled SDA low in the ninth clock.
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic oe_a, oe_b;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    w8(5); sda_m = 1'b1; w8(5); scl_m = 1'b1; w8(5);
    oe_a = sda_oe; acked = ~sda_line; w8(5); oe_b = sda_oe; scl_m = 1'b0;
    chk(oe_a == oe_b, "R9 sda enable steady while SCL high", {31'b0, oe_b}, {31'b0, oe_a});
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w8(10); scl_m = 1'b1; w8(5); b[i] = sda_line; w8(5); scl_m = 1'b0;
    end
    w8(5); sda_m = ~give_ack; w8(5); scl_m = 1'b1; w8(10); scl_m = 1'b0;
  endtask

  task automatic write_regs(input logic [7:0] p, input logic [31:0] w [4], input int n);
    logic ak;
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R2 address ack on write", {31'b0, ak}, 1);
    send_byte(p, ak);           chk(ak, "R3 pointer byte ack", {31'b0, ak}, 1);
    for (int k = 0; k < n; k++)
      for (int j = 3; j >= 0; j--) begin
        send_byte(w[k][j*8 +: 8], ak);
        chk(ak, "R3 data byte ack", {31'b0, ak}, 1);
      end
    bus_stop();
  endtask

  task automatic read_regs(input logic [7:0] p, input int n, output logic [31:0] r [4]);
    logic ak;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(p, ak);
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R5 read address ack", {31'b0, ak}, 1);
    for (int k = 0; k < n; k++)
      for (int j = 3; j >= 0; j--) begin
        recv_byte(!(k == n - 1 && j == 0), b);
        r[k][j*8 +: 8] = b;
      end
    bus_stop();
  endtask

  task automatic write1(input logic [7:0] p, input logic [31:0] v);
    logic [31:0] w [4];
    w = '{v, 0, 0, 0};
    write_regs(p, w, 1);
  endtask

  task automatic read1(input logic [7:0] p, output logic [31:0] v);
    logic [31:0] r [4];
    read_regs(p, 1, r);
    v = r[0];
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(sda_oe == 1'b0, "R10 sda released after reset", {31'b0, sda_oe}, 0);
    chk(sleep_o == 1'b0, "R10 sleep low after reset", {31'b0, sleep_o}, 0);
    read1(8'h24, v); chk(v == 0, "R10 locked after reset", v, 0);
    read1(8'h03, v); chk(v == 0, "R10 storage zero after reset", v, 0);
  endtask

  task automatic t_foreign_addr();
    logic ak;
    bus_start();
    send_byte({7'h2A, 1'b0}, ak); chk(!ak, "R2 no ack for foreign address", {31'b0, ak}, 0);
    send_byte(8'h00, ak);         chk(!ak, "R2 stays released after mismatch", {31'b0, ak}, 0);
    bus_stop();
  endtask

  task automatic t_locked();
    logic [31:0] v;
    write1(8'h02, 32'hDEAD_BEEF);
    read1(8'h02, v); chk(v == 0, "R6 storage write refused while locked", v, 0);
    write1(8'h24, 32'h2C41_3535);
    read1(8'h24, v); chk(v == 0, "R6 wrong key keeps lock", v, 0);
  endtask

  task automatic t_sleep();
    logic [31:0] v;
    write1(8'h20, 32'h1);
    chk(sleep_o == 1'b1, "R7 sleep set while locked", {31'b0, sleep_o}, 1);
    read1(8'h20, v); chk(v == 1, "R7 sleep reads back", v, 1);
    write1(8'h20, 32'h0);
    chk(sleep_o == 1'b0, "R7 sleep cleared", {31'b0, sleep_o}, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    write1(8'h24, 32'h2C41_3534);
    read1(8'h24, v); chk(v == 1, "R6 key unlocks", v, 1);
    write1(8'h24, 32'h0);
    read1(8'h24, v); chk(v == 1, "R6 unlock is sticky", v, 1);
  endtask

  task automatic t_burst();
    logic [31:0] w [4];
    logic [31:0] r [4];
    w = '{32'h0102_0304, 32'hA5B6_C7D8, 32'h8000_0001, 32'h0};
    write_regs(8'h01, w, 3);
    read_regs(8'h01, 3, r);
    for (int k = 0; k < 3; k++)
      chk(r[k] == w[k], "R4 burst write then burst read", r[k], w[k]);
    read_regs(8'h02, 1, r);
    chk(r[0] == w[1], "R5 single read, MSB first", r[0], w[1]);
  endtask

  task automatic t_partial_abort();
    logic ak;
    logic [31:0] v;
    write1(8'h04, 32'h1122_3344);
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h04, ak);
    send_byte(8'hFF, ak); send_byte(8'hEE, ak); send_byte(8'hDD, ak);
    bus_stop();
    read1(8'h04, v); chk(v == 32'h1122_3344, "R3 partial word discarded", v, 32'h1122_3344);
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h05, ak);
    bit_out(1'b1); bit_out(1'b0);
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R1 start mid-byte restarts address", {31'b0, ak}, 1);
    send_byte(8'h05, ak);
    send_byte(8'hCA, ak); send_byte(8'hFE, ak); send_byte(8'h00, ak); send_byte(8'h07, ak);
    bus_stop();
    read1(8'h05, v); chk(v == 32'hCAFE_0007, "R1 transfer after abort", v, 32'hCAFE_0007);
  endtask

  task automatic t_sensor();
    logic [31:0] r [4];
    logic [31:0] v;
    field_v = 12'h800;
    temp_v  = 12'h7FF;
    read_regs(8'h1D, 3, r);
    chk(r[0] == 32'h0000_07FF, "R8 temperature positive limit", r[0], 32'h0000_07FF);
    chk(r[1] == 32'h0, "R4 unmapped address in burst", r[1], 0);
    chk(r[2] == 32'hFFFF_F800, "R8 field negative limit", r[2], 32'hFFFF_F800);
    write1(8'h1F, 32'h1234_5678);
    read1(8'h1F, v); chk(v == 32'hFFFF_F800, "R8 write to readout ignored", v, 32'hFFFF_F800);
  endtask

  task automatic t_nack();
    logic ak;
    logic [7:0] b;
    bit held;
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h01, ak);
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    recv_byte(1'b0, b);
    chk(b == 8'h01, "R5 first read byte is bits 31:24", {24'b0, b}, 32'h01);
    held = 1'b1;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      w8(10); scl_m = 1'b1; w8(5); if (!sda_line) held = 1'b0; w8(5); scl_m = 1'b0;
    end
    chk(held, "R5 SDA released after not-acknowledge", {31'b0, held}, 1);
    bus_stop();
  endtask

  initial begin
    w8(10);
    rst_n = 1'b1;
    w8(10);
    t_reset();
    t_foreign_addr();
    t_locked();
    t_sleep();
    t_unlock();
    t_burst();
    t_partial_abort();
    t_sensor();
    t_nack();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule